// File: doc/BRIEF.md
# Wide-to-Narrow Clock-Crossing Word Splitter

This block carries data from a 64-bit producer to a 32-bit consumer that runs on an unrelated clock. Each accepted wide write is cut into a lower and an upper 32-bit half. Each half goes into its own asynchronous FIFO, and both FIFOs are written in the same cycle. On the narrow side a small steering controller reads the two FIFOs in turn and routes the selected one through an output multiplexer. The consumer therefore sees one continuous stream of 32-bit words: the lower half of each entry, then its upper half.

Each access is answered one cycle later in its own clock domain, with an acknowledge or with an error. The writer sees a full flag. The reader sees an empty flag and a fill count in 32-bit words. A request that cannot be served is refused with an error and leaves the storage untouched.

Top module: `wide_narrow_bridge`

## Requirements
- R1: The lower half of a wide write (`wr_data` bits 31:0) is delivered on `rd_data` before its upper half (bits 63:32). Words leave in the order the entries were written.
- R2: A write request made while `wr_full` is 0 is answered in the next write-clock cycle with `wr_ack`=1 and `wr_err`=0. No write request means neither response is raised.
- R3: A write request made while `wr_full` is 1 is answered in the next cycle with `wr_err`=1 and `wr_ack`=0. Nothing is stored, so the refused data never appears on the read side.
- R4: A read request made while `rd_empty` is 0 is answered in the next read-clock cycle with `rd_ack`=1, `rd_err`=0 and the next word on `rd_data`.
- R5: A read request made while `rd_empty` is 1 is answered in the next cycle with `rd_err`=1 and `rd_ack`=0, and it does not advance the word stream.
- R6: `rd_empty` is 1 whenever the FIFO that holds the next half has nothing visible. It is always 1 when no word is held, and `rd_count` is 0 whenever `rd_empty` is 1.
- R7: `wr_full` is 1 whenever 2^DEPTH_LOG2 wide entries are held. An entry counts as held until its upper half has been read.
- R8: `rd_count` gives the visible 32-bit words: twice the entries held, less one once an entry's lower half has been read. It never exceeds the words actually held.
- R9: After reset the steering selects the lower half, `rd_empty`=1, `wr_full`=0, `rd_count`=0, and all acknowledge and error outputs are 0.
- R10: Under unrelated clocks with both sides active at once, every accepted write becomes readable after the pointer synchronisers, and no word is lost, duplicated or reordered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side (wide bus) clock |
| wrst | input | 1 | Synchronous active-high reset, write domain |
| wr_req | input | 1 | Write request |
| wr_data | input | 64 | Wide write data |
| wr_ack | output | 1 | Write accepted, one cycle after the request |
| wr_err | output | 1 | Write refused because full |
| wr_full | output | 1 | No room for another wide entry |
| rclk | input | 1 | Read-side (narrow bus) clock |
| rrst | input | 1 | Synchronous active-high reset, read domain |
| rd_req | input | 1 | Read request |
| rd_data | output | 32 | Narrow read data, valid with `rd_ack` |
| rd_ack | output | 1 | Read served, one cycle after the request |
| rd_err | output | 1 | Read refused because empty |
| rd_empty | output | 1 | Next half not available |
| rd_count | output | 5 | Visible 32-bit words held |

## Verification
A half-select toggle that is stuck or starts on the wrong side shows up on the first acknowledged read after reset, as swapped or repeated halves on `rd_data`. A pointer that moves on a refused access shows up within one read, as a skipped word or as a refused value appearing in the stream. A fault in the pointer crossing or in the flag logic appears a few read-clock cycles after the writes go quiet: `rd_count`, `rd_empty` or `wr_full` then disagrees with the number of words the model holds. The behavioural model checks the response, data and flag bounds on every clock of both domains, so each of these faults is reported at the first cycle where it becomes visible.

// File: rtl/wnb_pkg.sv
package wnb_pkg;
  // which half FIFO the narrow side reads next
  typedef enum logic {HALF_LO = 1'b0, HALF_HI = 1'b1} half_sel_e;

  // one-cycle response to a bus access
  typedef struct packed {
    logic ack;
    logic err;
  } resp_t;
endpackage

// File: rtl/wnb_sync.sv
module wnb_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/wnb_half_fifo.sv
module wnb_half_fifo #(
  parameter int DW = 32,
  parameter int AW = 3   // at least 2
) (
  input  logic          wclk,
  input  logic          wrst,
  input  logic          wen,
  input  logic [DW-1:0] wdata,
  output logic          full,
  input  logic          rclk,
  input  logic          rrst,
  input  logic          ren,
  output logic [DW-1:0] rdata,
  output logic          empty,
  output logic [AW:0]   rlevel
);
  localparam int PW    = AW + 1;
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wbin, wgray, rbin, rgray;
  logic [PW-1:0] rgray_w, wgray_r, wbin_r;

  function automatic logic [PW-1:0] to_gray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] to_bin(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  // storage: one write port, one registered read port
  always_ff @(posedge wclk) begin
    if (wen) mem[wbin[AW-1:0]] <= wdata;
  end

  always_ff @(posedge rclk) begin
    if (ren) rdata <= mem[rbin[AW-1:0]];
  end

  // write pointer
  always_ff @(posedge wclk) begin
    if (wrst) begin
      wbin  <= '0;
      wgray <= '0;
    end else if (wen) begin
      wbin  <= wbin + 1'b1;
      wgray <= to_gray(wbin + 1'b1);
    end
  end

  // read pointer
  always_ff @(posedge rclk) begin
    if (rrst) begin
      rbin  <= '0;
      rgray <= '0;
    end else if (ren) begin
      rbin  <= rbin + 1'b1;
      rgray <= to_gray(rbin + 1'b1);
    end
  end

  wnb_sync #(.W(PW), .STAGES(2)) u_r2w (
    .clk(wclk), .rst(wrst), .d(rgray), .q(rgray_w)
  );

  wnb_sync #(.W(PW), .STAGES(2)) u_w2r (
    .clk(rclk), .rst(rrst), .d(wgray), .q(wgray_r)
  );

  // full: pointers differ only in the wrap bit (two top Gray bits flipped)
  assign full   = (wgray == {~rgray_w[PW-1:PW-2], rgray_w[PW-3:0]});
  assign empty  = (rgray == wgray_r);
  assign wbin_r = to_bin(wgray_r);
  assign rlevel = wbin_r - rbin;
endmodule

// File: rtl/wnb_write_gate.sv
module wnb_write_gate (
  input  logic clk,
  input  logic rst,
  input  logic req,
  input  logic lo_full,
  input  logic hi_full,
  output logic push,
  output logic full,
  output logic ack,
  output logic err
);
  import wnb_pkg::*;

  resp_t resp;

  assign full = lo_full | hi_full;
  assign push = req & ~full;

  always_ff @(posedge clk) begin
    if (rst) begin
      resp <= '0;
    end else begin
      resp.ack <= push;
      resp.err <= req & full;
    end
  end

  assign ack = resp.ack;
  assign err = resp.err;
endmodule

// File: rtl/wnb_read_steer.sv
module wnb_read_steer #(
  parameter int AW = 3
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        req,
  input  logic        lo_empty,
  input  logic        hi_empty,
  input  logic [AW:0] lo_level,
  input  logic [AW:0] hi_level,
  output logic        lo_ren,
  output logic        hi_ren,
  output logic        empty,
  output logic [AW+1:0] count,
  output logic        out_hi,
  output logic        ack,
  output logic        err
);
  import wnb_pkg::*;

  half_sel_e sel;
  half_sel_e last;
  resp_t     resp;
  logic      take;

  assign empty  = (sel == HALF_HI) ? hi_empty : lo_empty;
  assign take   = req & ~empty;
  assign lo_ren = take & (sel == HALF_LO);
  assign hi_ren = take & (sel == HALF_HI);

  always_ff @(posedge clk) begin
    if (rst) begin
      sel  <= HALF_LO;
      last <= HALF_LO;
      resp <= '0;
    end else begin
      resp.ack <= take;
      resp.err <= req & empty;
      if (take) begin
        last <= sel;
        sel  <= (sel == HALF_LO) ? HALF_HI : HALF_LO;
      end
    end
  end

  assign count  = {1'b0, lo_level} + {1'b0, hi_level};
  assign out_hi = (last == HALF_HI);
  assign ack    = resp.ack;
  assign err    = resp.err;
endmodule

// File: rtl/wide_narrow_bridge.sv
module wide_narrow_bridge #(
  parameter int WIDE_W     = 64,
  parameter int DEPTH_LOG2 = 3
) (
  input  logic                  wclk,
  input  logic                  wrst,
  input  logic                  wr_req,
  input  logic [WIDE_W-1:0]     wr_data,
  output logic                  wr_ack,
  output logic                  wr_err,
  output logic                  wr_full,
  input  logic                  rclk,
  input  logic                  rrst,
  input  logic                  rd_req,
  output logic [WIDE_W/2-1:0]   rd_data,
  output logic                  rd_ack,
  output logic                  rd_err,
  output logic                  rd_empty,
  output logic [DEPTH_LOG2+1:0] rd_count
);
  localparam int HALF_W = WIDE_W / 2;

  logic                  push;
  logic [1:0]            half_full, half_empty, half_ren;
  logic [HALF_W-1:0]     half_q     [2];
  logic [DEPTH_LOG2:0]   half_level [2];
  logic                  out_hi;

  wnb_write_gate u_wgate (
    .clk(wclk), .rst(wrst), .req(wr_req),
    .lo_full(half_full[0]), .hi_full(half_full[1]),
    .push(push), .full(wr_full), .ack(wr_ack), .err(wr_err)
  );

  for (genvar h = 0; h < 2; h++) begin : g_half
    wnb_half_fifo #(.DW(HALF_W), .AW(DEPTH_LOG2)) u_fifo (
      .wclk(wclk), .wrst(wrst), .wen(push),
      .wdata(wr_data[h*HALF_W +: HALF_W]), .full(half_full[h]),
      .rclk(rclk), .rrst(rrst), .ren(half_ren[h]),
      .rdata(half_q[h]), .empty(half_empty[h]), .rlevel(half_level[h])
    );
  end

  wnb_read_steer #(.AW(DEPTH_LOG2)) u_steer (
    .clk(rclk), .rst(rrst), .req(rd_req),
    .lo_empty(half_empty[0]), .hi_empty(half_empty[1]),
    .lo_level(half_level[0]), .hi_level(half_level[1]),
    .lo_ren(half_ren[0]), .hi_ren(half_ren[1]),
    .empty(rd_empty), .count(rd_count), .out_hi(out_hi),
    .ack(rd_ack), .err(rd_err)
  );

  assign rd_data = out_hi ? half_q[1] : half_q[0];
endmodule

// File: rtl/wnb_checks.sv
module wnb_checks #(
  parameter int CW = 5
) (
  input logic          wclk,
  input logic          wrst,
  input logic          wr_req,
  input logic          wr_ack,
  input logic          wr_err,
  input logic          wr_full,
  input logic          rclk,
  input logic          rrst,
  input logic          rd_req,
  input logic          rd_ack,
  input logic          rd_err,
  input logic          rd_empty,
  input logic [CW-1:0] rd_count
);
  AST_WR_ACK: assert property (@(posedge wclk) disable iff (wrst)
    wr_req && !wr_full |=> wr_ack && !wr_err);                   // R2
  AST_WR_IDLE: assert property (@(posedge wclk) disable iff (wrst)
    !wr_req |=> !wr_ack && !wr_err);                             // R2
  AST_WR_ERR_FULL: assert property (@(posedge wclk) disable iff (wrst)
    wr_req && wr_full |=> wr_err && !wr_ack);                    // R3
  AST_RD_ACK: assert property (@(posedge rclk) disable iff (rrst)
    rd_req && !rd_empty |=> rd_ack && !rd_err);                  // R4
  AST_RD_ERR_EMPTY: assert property (@(posedge rclk) disable iff (rrst)
    rd_req && rd_empty |=> rd_err && !rd_ack);                   // R5
  AST_EMPTY_NO_COUNT: assert property (@(posedge rclk) disable iff (rrst)
    rd_empty |-> rd_count == '0);                                // R6
endmodule

bind wide_narrow_bridge wnb_checks #(.CW(DEPTH_LOG2 + 2)) u_checks (
  .wclk(wclk), .wrst(wrst), .wr_req(wr_req), .wr_ack(wr_ack),
  .wr_err(wr_err), .wr_full(wr_full), .rclk(rclk), .rrst(rrst),
  .rd_req(rd_req), .rd_ack(rd_ack), .rd_err(rd_err),
  .rd_empty(rd_empty), .rd_count(rd_count)
);

// File: tb/wide_narrow_bridge_test.sv
`timescale 1ns/1ps
module wide_narrow_bridge_test;
  localparam int CLK_PERIOD  = 10;
  localparam int RCLK_PERIOD = 17;
  localparam int DL2   = 3;
  localparam int DEPTH = 1 << DL2;

  logic        wclk = 0, rclk = 0;
  logic        wrst = 1, rrst = 1;
  logic        wr_req = 0, rd_req = 0;
  logic [63:0] wr_data = '0;
  logic        wr_ack, wr_err, wr_full;
  logic [31:0] rd_data;
  logic        rd_ack, rd_err, rd_empty;
  logic [DL2+1:0] rd_count;

  always #(CLK_PERIOD/2.0)  wclk = ~wclk;
  always #(RCLK_PERIOD/2.0) rclk = ~rclk;

  wide_narrow_bridge #(.WIDE_W(64), .DEPTH_LOG2(DL2)) uut (.*);

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  bit wr_done = 0;
  logic [31:0] model_q [$];

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- write-side model ----------------
  bit          ws_req, ws_full;
  logic [63:0] ws_dat;
  always @(posedge wclk) begin
    ws_req  = wr_req && !wrst;
    ws_full = wr_full;
    ws_dat  = wr_data;
  end

  always @(negedge wclk) begin
    if (!wrst) begin
      chk(wr_ack == (ws_req && !ws_full), "R2 wr_ack", 64'(wr_ack), 64'(ws_req && !ws_full));
      chk(wr_err == (ws_req && ws_full), "R3 wr_err", 64'(wr_err), 64'(ws_req && ws_full));
      if (ws_req && !ws_full) begin
        model_q.push_back(ws_dat[31:0]);
        model_q.push_back(ws_dat[63:32]);
      end
      if ((model_q.size() + 1) / 2 == DEPTH)
        chk(wr_full == 1'b1, "R7 full at capacity", 64'(wr_full), 64'd1);
    end
  end

  // ---------------- read-side model ----------------
  bit rs_req, rs_empty;
  always @(posedge rclk) begin
    rs_req   = rd_req && !rrst;
    rs_empty = rd_empty;
  end

  always @(negedge rclk) begin
    if (!rrst) begin
      logic [31:0] exp_w;
      chk(rd_ack == (rs_req && !rs_empty), "R4 rd_ack", 64'(rd_ack), 64'(rs_req && !rs_empty));
      chk(rd_err == (rs_req && rs_empty), "R5 rd_err", 64'(rd_err), 64'(rs_req && rs_empty));
      if (rs_req && !rs_empty) begin
        if (model_q.size() == 0) begin
          chk(1'b0, "R5 read with no word held", 64'(rd_data), 64'd0);
        end else begin
          exp_w = model_q.pop_front();
          chk(rd_data == exp_w, "R1 word order/data", 64'(rd_data), 64'(exp_w));
        end
      end
      if (model_q.size() == 0)
        chk(rd_empty == 1'b1, "R6 empty with no words", 64'(rd_empty), 64'd1);
      chk(int'(rd_count) <= model_q.size(), "R8 count bound", 64'(rd_count), 64'(model_q.size()));
    end
  end

  // ---------------- drivers ----------------
  task automatic wr_cycle(input bit req, input logic [63:0] d);
    @(negedge wclk);
    wr_req  = req;
    wr_data = d;
  endtask

  task automatic rd_cycle(input bit req);
    @(negedge rclk);
    rd_req = req;
  endtask

  task automatic rd_idle(input int n);
    for (int i = 0; i < n; i++) rd_cycle(1'b0);
  endtask

  task automatic writer_random(input int n);
    for (int i = 0; i < n; i++) begin
      wr_cycle(($urandom % 3) != 0, {$urandom, $urandom});
    end
    wr_cycle(1'b0, '0);
    wr_done = 1;
  endtask

  task automatic reader_random();
    int guard = 0;
    while (!(wr_done && model_q.size() == 0) && guard < 20000) begin
      rd_cycle(($urandom % 4) != 0);
      guard++;
    end
    rd_cycle(1'b0);
  endtask

  initial begin
    repeat (6) @(negedge rclk);
    wrst = 0;
    rrst = 0;
    @(negedge rclk);
    // R9: state after reset
    chk(rd_empty == 1'b1, "R9 reset empty", 64'(rd_empty), 64'd1);
    chk(wr_full == 1'b0, "R9 reset full", 64'(wr_full), 64'd0);
    chk(rd_count == 0, "R9 reset count", 64'(rd_count), 64'd0);
    chk(!rd_ack && !rd_err && !wr_ack && !wr_err, "R9 reset responses",
        64'({rd_ack, rd_err, wr_ack, wr_err}), 64'd0);

    // R5: read while empty
    rd_cycle(1'b1);
    rd_cycle(1'b0);
    rd_idle(2);
    chk(rd_count == 0, "R5 count after refused read", 64'(rd_count), 64'd0);

    // R8: count with a partly read entry
    for (int i = 0; i < 3; i++) wr_cycle(1'b1, {32'hA000_0000 + 32'(i), 32'h5000_0000 + 32'(i)});
    wr_cycle(1'b0, '0);
    rd_idle(8);
    chk(rd_count == 6, "R8 count three entries", 64'(rd_count), 64'd6);
    rd_cycle(1'b1);
    rd_cycle(1'b0);
    chk(rd_count == 5, "R8 count after lower half read", 64'(rd_count), 64'd5);
    for (int i = 0; i < 5; i++) rd_cycle(1'b1);
    rd_cycle(1'b0);
    rd_idle(6);
    chk(rd_empty == 1'b1, "R6 drained empty", 64'(rd_empty), 64'd1);

    // R3/R7: fill past capacity; refused data must not appear
    for (int i = 0; i < DEPTH + 2; i++) wr_cycle(1'b1, {32'hC000_0000 + 32'(i), 32'h3000_0000 + 32'(i)});
    wr_cycle(1'b0, '0);
    rd_idle(8);
    chk(wr_full == 1'b1, "R7 full after fill", 64'(wr_full), 64'd1);
    chk(rd_count == 2 * DEPTH, "R8 count when full", 64'(rd_count), 64'(2 * DEPTH));
    for (int i = 0; i < 2 * DEPTH + 1; i++) rd_cycle(1'b1);
    rd_cycle(1'b0);
    rd_idle(6);
    chk(rd_count == 0, "R3 no refused data stored", 64'(rd_count), 64'd0);
    repeat (6) @(negedge wclk);
    chk(wr_full == 1'b0, "R7 full clears after drain", 64'(wr_full), 64'd0);

    // R10: both sides active on unrelated clocks
    fork
      writer_random(300);
      reader_random();
    join
    rd_idle(8);
    chk(model_q.size() == 0, "R10 all words delivered", 64'(model_q.size()), 64'd0);
    chk(rd_empty == 1'b1 && rd_count == 0, "R10 empty at end", 64'({rd_empty, rd_count}), 64'({1'b1, 5'd0}));
    chk(wr_full == 1'b0, "R10 not full at end", 64'(wr_full), 64'd0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule